// File: doc/BRIEF.md
# Serial-Port Frame Sync and Driver-Enable Generator

This block produces the framing signals for a time-division serial data port whose frame carries two 8-bit bearer channels (B1, B2) and a signalling (D) channel. It runs from the bit clock and keeps a bit-slot counter that gives the position of the current bit within the frame. It drives an active-low driver enable that can open the data output for the bearer bits, the signalling bits, or both. A bus or backplane driver can be gated directly from it.

As master, the block drives the frame syncs. A single sync can time both directions, or separate transmit and receive syncs can be used. Each sync can be a one-clock short pulse or an eight-clock long pulse. As slave, it realigns its slot counter to the rising edge of the incoming sync and classifies that pulse as short or long from its measured width. A six-bit configuration register selects the mode. The register refuses combinations that cannot coexist: dual syncs together with a driver enable, and long sync together with timeslot-assignment mode.

Top module: `tdm_fsync_gen`

## Requirements
- R1: After hardware reset, `slot_pos_o` is 0, `den_n_o` is 1, both sync outputs are 0, `sync_long_o` is 0, and every configuration bit is 0.
- R2: A one-clock pulse on `soft_rst` clears every configuration bit. From the second clock after the pulse, the outputs behave as with an all-zero configuration.
- R3: In master mode, `slot_pos_o` counts 0, 1, … FRAME_BITS-1 and then returns to 0, advancing once per clock.
- R4: With a master short single sync (configuration 0), `fs_main_o` is 1 only while `slot_pos_o` equals FRAME_BITS-1 (the bit just before the first B1 bit), and `fs_tx_o` stays 0.
- R5: With the long-sync bit (bit 1) set as master, `fs_main_o` is 1 for eight clocks: slot FRAME_BITS-1 and slots 0 to 6. This holds in both channel formats.
- R6: With the dual-sync bit (bit 0) set as master, `fs_tx_o` carries the sync at frame timing and `fs_main_o` carries the receive sync RX_OFFSET clocks later. A write that requests dual sync together with either driver-enable bit (bits 4, 5) stores dual sync as 0.
- R7: In the 10-bit format (format bit 2 = 0), B1 occupies slots 0-7 and B2 slots 10-17. D occupies slots 8 and 18. Slots 9 and 19 are spare.
- R8: In the 8-bit format (bit 2 = 1), B1 and B2 occupy slots 0-15 and D occupies slots 16-17.
- R9: With timeslot-assignment mode (bit 3) set, the 8-bit layout applies whatever bit 2 holds. A write that requests long sync together with this mode stores long sync as 0.
- R10: `den_n_o` is 0 exactly when the B-enable (bit 4) is set and the slot is a B slot, or when the D-enable (bit 5) is set and the slot is a D slot. It is 1 in spare and idle slots.
- R11: In slave mode, a rising edge on the selected sync input moves `slot_pos_o` to 0 on the next clock. The selected input is `fs_tx_in` when dual sync is on and `fs_in` otherwise. Both sync outputs stay 0 in slave mode.
- R12: In slave mode, one clock after a sync pulse ends, `sync_long_o` becomes 1 if the pulse lasted 2 or more clocks and 0 if it lasted 1 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Synchronous clear of the configuration register |
| master | input | 1 | 1 = drive the syncs, 0 = follow incoming syncs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Bit 0 dual, 1 long, 2 8-bit format, 3 timeslot assignment, 4 B-enable, 5 D-enable |
| fs_in | input | 1 | Incoming sync (single mode) in slave |
| fs_tx_in | input | 1 | Incoming transmit sync (dual mode) in slave |
| fs_main_o | output | 1 | Single sync, or receive sync in dual mode |
| fs_tx_o | output | 1 | Transmit sync in dual mode |
| den_n_o | output | 1 | Active-low driver enable |
| slot_pos_o | output | PW | Current bit slot in the frame |
| sync_long_o | output | 1 | Slave: last incoming sync was long |

## Verification
The driver enable is exercised with the B-enable and D-enable both set under the 10-bit format, the 8-bit format, and timeslot mode with the format bit left at 0. The window edges at slots 7/8/9/10 and 15/16/17/18 separate the two layouts and show whether the format bit is overridden. Master syncs are compared in short, long, dual and rejected-dual configurations, where width and offset tell the shapes apart. In slave mode, a one-clock pulse and an eight-clock pulse on each sync input check the realignment point and the width classification.

// File: rtl/tdm_fsync_pkg.sv
package tdm_fsync_pkg;

  localparam int CFG_W = 6;

  // Packed order gives bit 0 = dual ... bit 5 = den_d.
  typedef struct packed {
    logic den_d;
    logic den_b;
    logic tsa;
    logic fmt8;
    logic long_fs;
    logic dual;
  } cfg_t;

  // Drop settings that may not coexist with others in the same write.
  function automatic cfg_t cfg_sanitize(input logic [CFG_W-1:0] raw);
    cfg_t c;
    c = cfg_t'(raw);
    if (c.den_b || c.den_d) c.dual = 1'b0;
    if (c.tsa) c.long_fs = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/tdm_fsync_cfg.sv
module tdm_fsync_cfg
  import tdm_fsync_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg
);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) cfg <= '0;
    else if (we)         cfg <= cfg_sanitize(wdata);
  end

  a_r6_no_dual_with_den: assert property (@(posedge clk) disable iff (rst)
    !(cfg.dual && (cfg.den_b || cfg.den_d)));

  a_r9_no_long_in_tsa: assert property (@(posedge clk) disable iff (rst)
    !(cfg.tsa && cfg.long_fs));

  a_r2_soft_clears: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (cfg == '0));

endmodule

// File: rtl/tdm_fsync_counter.sv
module tdm_fsync_counter #(
  parameter int FRAME_BITS = 32,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          sync_sel,
  output logic [PW-1:0] cnt_q,
  output logic [PW-1:0] cnt_next,
  output logic          long_det
);

  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic       prev_q;
  logic [1:0] wid_q;
  logic       rise;
  logic       fall;

  assign rise = sync_sel && !prev_q;
  assign fall = !sync_sel && prev_q;

  always_comb begin
    if (!master && rise)   cnt_next = '0;
    else if (cnt_q == LAST) cnt_next = '0;
    else                    cnt_next = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      prev_q   <= 1'b0;
      wid_q    <= '0;
      long_det <= 1'b0;
    end else begin
      cnt_q  <= cnt_next;
      prev_q <= sync_sel;
      if (rise)                       wid_q <= 2'd1;
      else if (sync_sel && wid_q < 2) wid_q <= wid_q + 2'd1;
      if (!master && fall)            long_det <= (wid_q >= 2'd2);
    end
  end

  a_r11_realign: assert property (@(posedge clk) disable iff (rst)
    (!master && sync_sel && !prev_q) |=> (cnt_q == '0));

  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (master && cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/tdm_fsync_decode.sv
module tdm_fsync_decode
  import tdm_fsync_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int LONG_W     = 8,
  parameter int RX_OFFSET  = 4,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic [PW-1:0] pos,
  input  cfg_t          cfg,
  input  logic          master,
  output logic          den_n,
  output logic          fs_main,
  output logic          fs_tx
);

  function automatic logic sync_shape(input int q, input logic lng);
    if (q == FRAME_BITS - 1) return 1'b1;
    if (lng && q < LONG_W - 1) return 1'b1;
    return 1'b0;
  endfunction

  int   p;
  int   p_rx;
  logic fmt8_eff;
  logic in_b;
  logic in_d;

  always_comb begin
    p        = int'(pos);
    p_rx     = (p >= RX_OFFSET) ? p - RX_OFFSET : p + FRAME_BITS - RX_OFFSET;
    fmt8_eff = cfg.fmt8 || cfg.tsa;
    if (fmt8_eff) begin
      in_b = (p < 16);
      in_d = (p == 16) || (p == 17);
    end else begin
      in_b = (p < 8) || (p >= 10 && p < 18);
      in_d = (p == 8) || (p == 18);
    end
    den_n = !((cfg.den_b && in_b) || (cfg.den_d && in_d));
    if (!master) begin
      fs_main = 1'b0;
      fs_tx   = 1'b0;
    end else if (cfg.dual) begin
      fs_main = sync_shape(p_rx, cfg.long_fs);
      fs_tx   = sync_shape(p, cfg.long_fs);
    end else begin
      fs_main = sync_shape(p, cfg.long_fs);
      fs_tx   = 1'b0;
    end
  end

endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
  import tdm_fsync_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int LONG_W     = 8,
  parameter int RX_OFFSET  = 4,
  localparam int PW = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             master,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             fs_in,
  input  logic             fs_tx_in,
  output logic             fs_main_o,
  output logic             fs_tx_o,
  output logic             den_n_o,
  output logic [PW-1:0]    slot_pos_o,
  output logic             sync_long_o
);

  cfg_t          cfg;
  logic [PW-1:0] cnt_next;
  logic          sync_sel;
  logic          den_n_d;
  logic          fs_main_d;
  logic          fs_tx_d;

  assign sync_sel = cfg.dual ? fs_tx_in : fs_in;

  tdm_fsync_cfg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .cfg      (cfg)
  );

  tdm_fsync_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .master   (master),
    .sync_sel (sync_sel),
    .cnt_q    (slot_pos_o),
    .cnt_next (cnt_next),
    .long_det (sync_long_o)
  );

  tdm_fsync_decode #(
    .FRAME_BITS (FRAME_BITS),
    .LONG_W     (LONG_W),
    .RX_OFFSET  (RX_OFFSET)
  ) u_dec (
    .pos     (cnt_next),
    .cfg     (cfg),
    .master  (master),
    .den_n   (den_n_d),
    .fs_main (fs_main_d),
    .fs_tx   (fs_tx_d)
  );

  // Outputs are registered from the next slot so they align with slot_pos_o.
  always_ff @(posedge clk) begin
    if (rst) begin
      den_n_o   <= 1'b1;
      fs_main_o <= 1'b0;
      fs_tx_o   <= 1'b0;
    end else begin
      den_n_o   <= den_n_d;
      fs_main_o <= fs_main_d;
      fs_tx_o   <= fs_tx_d;
    end
  end

  a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
    (int'(slot_pos_o) >= 20) |-> den_n_o);

  a_r11_slave_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(master) |-> (!fs_main_o && !fs_tx_o));

  a_r6_tx_single_low: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg.dual) |-> !fs_tx_o);

endmodule

// File: tb/tdm_fsync_gen_bench.sv
module tdm_fsync_gen_bench;
  import tdm_fsync_pkg::*;

  localparam int PERIOD = 10;
  localparam int FB     = 32;
  localparam int RXO    = 4;
  localparam int PW     = $clog2(FB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_rst = 1'b0;
  logic master = 1'b1;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic fs_in = 1'b0;
  logic fs_tx_in = 1'b0;
  logic fs_main_o, fs_tx_o, den_n_o, sync_long_o;
  logic [PW-1:0] slot_pos_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tdm_fsync_gen #(.FRAME_BITS(FB), .LONG_W(8), .RX_OFFSET(RXO)) u_tdm_fsync_gen (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .master(master),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .fs_in(fs_in), .fs_tx_in(fs_tx_in),
    .fs_main_o(fs_main_o), .fs_tx_o(fs_tx_o), .den_n_o(den_n_o),
    .slot_pos_o(slot_pos_o), .sync_long_o(sync_long_o)
  );

  // Bench model built from the requirements.
  logic [5:0] m_cfg;
  int   m_pos;
  logic m_prev;
  logic m_den_n, m_fsm, m_fst;

  function automatic logic [5:0] clean(input logic [5:0] w);
    logic [5:0] c;
    c = w;
    if (c[4] || c[5]) c[0] = 1'b0;
    if (c[3]) c[1] = 1'b0;
    return c;
  endfunction

  function automatic logic shape(input int q, input logic lng);
    return (q == FB - 1) || (lng && q <= 6);
  endfunction

  function automatic logic exp_den(input int q, input logic [5:0] c);
    logic b, d;
    if (c[2] || c[3]) begin
      b = q <= 15;
      d = q == 16 || q == 17;
    end else begin
      b = q <= 7 || (q >= 10 && q <= 17);
      d = q == 8 || q == 18;
    end
    return !((c[4] && b) || (c[5] && d));
  endfunction

  always @(posedge clk) begin
    int np;
    logic sel;
    if (rst) begin
      m_pos <= 0; m_prev <= 1'b0; m_cfg <= '0;
      m_den_n <= 1'b1; m_fsm <= 1'b0; m_fst <= 1'b0;
    end else begin
      sel = m_cfg[0] ? fs_tx_in : fs_in;
      if (!master && sel && !m_prev) np = 0;
      else np = (m_pos + 1) % FB;
      m_den_n <= exp_den(np, m_cfg);
      if (!master) begin
        m_fsm <= 1'b0; m_fst <= 1'b0;
      end else if (m_cfg[0]) begin
        m_fst <= shape(np, m_cfg[1]);
        m_fsm <= shape((np + FB - RXO) % FB, m_cfg[1]);
      end else begin
        m_fst <= 1'b0;
        m_fsm <= shape(np, m_cfg[1]);
      end
      m_pos  <= np;
      m_prev <= sel;
      if (soft_rst)    m_cfg <= '0;
      else if (cfg_we) m_cfg <= clean(cfg_wdata);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "slot_pos", int'(slot_pos_o), m_pos);
    chk(req, "den_n", int'(den_n_o), int'(m_den_n));
    chk(req, "fs_main", int'(fs_main_o), int'(m_fsm));
    chk(req, "fs_tx", int'(fs_tx_o), int'(m_fst));
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all(req);
    end
  endtask

  task automatic write_cfg(input logic [5:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "slot_pos", int'(slot_pos_o), 0);
    chk("R1", "den_n", int'(den_n_o), 1);
    chk("R1", "fs_main", int'(fs_main_o), 0);
    chk("R1", "fs_tx", int'(fs_tx_o), 0);
    chk("R1", "sync_long", int'(sync_long_o), 0);
  endtask

  task automatic t_short_master();
    run(2 * FB, "R3");   // R3 count and wrap, R4 short sync
    run(FB, "R4");
  endtask

  task automatic t_long_master();
    write_cfg(6'h02); run(2 * FB, "R5");
    write_cfg(6'h06); run(FB, "R5");
  endtask

  task automatic t_fmt10();
    write_cfg(6'h30); run(2 * FB, "R7");
    write_cfg(6'h10); run(FB, "R10");
    write_cfg(6'h20); run(FB, "R10");
  endtask

  task automatic t_fmt8();
    write_cfg(6'h34); run(2 * FB, "R8");
  endtask

  task automatic t_tsa();
    // R9: format bit 0 and long requested; 8-bit layout and short sync expected
    write_cfg(6'h3A); run(2 * FB, "R9");
  endtask

  task automatic t_dual();
    write_cfg(6'h01); run(2 * FB, "R6");
    write_cfg(6'h03); run(FB, "R6");
    write_cfg(6'h11); run(FB, "R6");  // dual rejected
  endtask

  task automatic t_soft();
    write_cfg(6'h36);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    @(negedge clk);
    run(FB, "R2");
  endtask

  task automatic pulse(input bit tx, input int w);
    @(negedge clk);
    if (tx) fs_tx_in = 1'b1; else fs_in = 1'b1;
    check_all("R11");
    for (int i = 1; i < w; i++) begin
      @(negedge clk); check_all("R11");
    end
    @(negedge clk);
    fs_in = 1'b0; fs_tx_in = 1'b0;
    check_all("R11");
  endtask

  task automatic t_slave();
    write_cfg(6'h30);
    master = 1'b0;
    run(7, "R11");
    pulse(1'b0, 1);
    @(negedge clk); check_all("R11");
    chk("R12", "sync_long short", int'(sync_long_o), 0);
    run(FB + 5, "R11");
    pulse(1'b0, 8);
    @(negedge clk); check_all("R11");
    chk("R12", "sync_long long", int'(sync_long_o), 1);
    run(13, "R11");
    pulse(1'b0, 2);
    @(negedge clk);
    chk("R12", "sync_long width2", int'(sync_long_o), 1);
    pulse(1'b0, 1);
    @(negedge clk);
    chk("R12", "sync_long width1", int'(sync_long_o), 0);
    write_cfg(6'h01);
    run(9, "R11");
    pulse(1'b0, 1);     // ignored input in dual mode
    run(11, "R11");
    pulse(1'b1, 1);
    run(FB, "R11");
    master = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_short_master();
    t_long_master();
    t_fmt10();
    t_fmt8();
    t_tsa();
    t_dual();
    t_soft();
    t_slave();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule